// File: doc/BRIEF.md
# Serial Cyclic Check-Word Codec

This block computes and checks the 16-bit error-check word of a 64-bit code word, one bit per strobe. A code word is 48 message bits followed by a 15-bit polynomial remainder and one even-parity bit. Bits move most significant bit first, so each byte goes bit 7 first. In generate mode the block takes the 48 message bits and returns the 16-bit check word, ready to be appended. In check mode it takes all 64 bits and returns a pass flag and a 16-bit syndrome. The syndrome can be read as a low byte and a high byte.

The upstream bit recovery logic drives `bit_valid` for every bit. It raises `word_start` together with the first bit of each word. `mode_check` is sampled only on that first bit and picks the role for the whole word. The results are registered and stay in place until the next word of the same role completes. `word_done` pulses for one cycle when a result has been updated.

Top module: `cc_codec`

## Requirements
- R1: In generate mode (`mode_check`=0 on the first bit), after the 48th accepted bit, `check_word[15:2]` equals bits 14..1 of the remainder of M(x)·x^15 divided modulo 2 by x^15+x^14+x^13+x^11+x^4+x^2+1. Here M is the 48 message bits, first bit as the highest power, and remainder bit k is the coefficient of x^k.
- R2: In generate mode, `check_word[1]` is the inverse of remainder bit 0.
- R3: In generate mode, `check_word[0]` is chosen so that the 48 message bits plus `check_word[15:1]` have even parity.
- R4: In check mode, a word built as message followed by its R1–R3 check word (MSB first) gives `word_ok`=1 and an all-zero syndrome.
- R5: In check mode, the syndrome bits S1..S15 are the remainder, S(k) = coefficient of x^(k-1), of D(x)·x^15 modulo the same polynomial. D is received bits 1..63 with bit 63 inverted. S1..S8 appear on `syndrome_lo[0..7]` and S9..S15 on `syndrome_hi[0..6]`.
- R6: `syndrome_hi[7]` is the XOR of the even parity of received bits 1..63 with received bit 64. `word_ok` is 1 only when S1..S15 are all zero and this flag is 0.
- R7: `word_start` with `bit_valid` restarts the word at once: the divider and the parity restart from zero at that bit, whatever bits came before.
- R8: Cycles without `bit_valid` are ignored. Valid bits beyond the word length, without a new `word_start`, are ignored and change no output.
- R9: `word_done` is high for exactly one cycle, the cycle after the final bit is accepted. `check_word` changes only at the end of a generate word. The syndrome and `word_ok` change only at the end of a check word.
- R10: After reset all outputs are zero.
- R11: The role is the value of `mode_check` on the first bit. Later changes of `mode_check` within the word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | Qualifies `bit_in` this cycle |
| bit_in | input | 1 | Serial data bit, MSB first |
| word_start | input | 1 | Marks the first bit of a word (with `bit_valid`) |
| mode_check | input | 1 | 0 = generate check word, 1 = check received word |
| check_word | output | 16 | Generated check word, first-sent bit in bit 15 |
| syndrome_lo | output | 8 | S1..S8 |
| syndrome_hi | output | 8 | S9..S15 in bits 0..6, parity error in bit 7 |
| word_ok | output | 1 | Last checked word passed |
| word_done | output | 1 | One-cycle pulse: a result was updated |

## Verification
The bench builds the block with its defaults: 48 message bits and the 15-bit generator. It checks the codec against a long-division model that works on whole polynomials, not on a shift register. Every one of the 64 single-bit error positions is swept on two messages. This covers syndrome mapping, the inverted bit 63 and the parity flag at each position. Further cases cover a batch of messages including all-zero and all-one, idle gaps carrying junk data, aborted words restarted by `word_start`, surplus bits, and a mode change in mid-word.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int CC_REM_W = 15;
  localparam logic [CC_REM_W-1:0] CC_POLY = 15'h6815;  // x^14+x^13+x^11+x^4+x^2+1 (x^15 implied)
  localparam int CC_MSG_BITS = 48;

  typedef logic [CC_REM_W-1:0] rem_t;

  // One step of the remainder register: shifts one message bit in, MSB-first.
  function automatic rem_t lfsr_step(rem_t rem, logic b, rem_t poly);
    logic fb;
    fb = b ^ rem[CC_REM_W-1];
    return {rem[CC_REM_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

  // Even parity bit over the remainder after the last bit has been inverted.
  function automatic logic sent_rem_parity(rem_t rem);
    return ~(^rem);
  endfunction
endpackage

// File: rtl/cc_bitseq.sv
module cc_bitseq #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             word_start,
  input  logic [IDX_W-1:0] word_len,
  output logic             accept,
  output logic             last,
  output logic [IDX_W-1:0] cur_idx
);
  logic [IDX_W-1:0] idx_q;
  logic             active_q;

  assign cur_idx = word_start ? '0 : idx_q;
  assign accept  = bit_valid && (word_start || active_q);
  assign last    = accept && (cur_idx == word_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      active_q <= 1'b0;
    end else if (accept) begin
      idx_q    <= cur_idx + 1'b1;
      active_q <= !last;
    end
  end

  assert_idx_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> idx_q < word_len);
  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(idx_q) && $stable(active_q));
endmodule

// File: rtl/cc_divider.sv
module cc_divider
  import cc_pkg::*;
#(
  parameter rem_t POLY = CC_POLY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clear,
  input  logic div_bit,
  input  logic par_bit,
  output rem_t rem_q,
  output logic par_q,
  output rem_t rem_next,
  output logic par_next
);
  rem_t rem_base;

  assign rem_base = clear ? '0 : rem_q;
  assign rem_next = lfsr_step(rem_base, div_bit, POLY);
  assign par_next = (clear ? 1'b0 : par_q) ^ par_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      par_q <= 1'b0;
    end else if (en) begin
      rem_q <= rem_next;
      par_q <= par_next;
    end
  end

  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en && clear |=> par_q == $past(par_bit));
endmodule

// File: rtl/cc_codec.sv
module cc_codec
  import cc_pkg::*;
#(
  parameter int   MSG_BITS = CC_MSG_BITS,
  parameter rem_t POLY     = CC_POLY
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_valid,
  input  logic                 bit_in,
  input  logic                 word_start,
  input  logic                 mode_check,
  output logic [CC_REM_W:0]    check_word,
  output logic [7:0]           syndrome_lo,
  output logic [CC_REM_W-8:0]  syndrome_hi,
  output logic                 word_ok,
  output logic                 word_done
);
  localparam int CW_W   = CC_REM_W + 1;
  localparam int RX_LEN = MSG_BITS + CW_W;
  localparam int IDX_W  = $clog2(RX_LEN + 1);

  logic             start_acc, mode_q, mode_cur;
  logic             accept, last, inv_bit, div_en;
  logic [IDX_W-1:0] cur_idx, word_len;
  rem_t             rem_q, rem_next;
  logic             par_q, par_next;
  logic             tx_done, rx_done, perr;
  logic [CW_W-1:0]  cw_q, syn_q;
  logic             ok_q, done_q;

  assign start_acc = bit_valid && word_start;
  assign mode_cur  = start_acc ? mode_check : mode_q;
  assign word_len  = mode_cur ? IDX_W'(RX_LEN) : IDX_W'(MSG_BITS);

  cc_bitseq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .word_start(word_start),
    .word_len(word_len), .accept(accept), .last(last), .cur_idx(cur_idx)
  );

  // Checker inverts received bit 63 before division; bit 64 bypasses the divider.
  assign inv_bit = mode_cur && (cur_idx == IDX_W'(RX_LEN - 2));
  assign div_en  = accept && !(mode_cur && last);

  cc_divider #(.POLY(POLY)) u_div (
    .clk(clk), .rst_n(rst_n), .en(div_en), .clear(word_start),
    .div_bit(bit_in ^ inv_bit), .par_bit(bit_in),
    .rem_q(rem_q), .par_q(par_q), .rem_next(rem_next), .par_next(par_next)
  );

  assign tx_done = accept && last && !mode_cur;
  assign rx_done = accept && last && mode_cur;
  assign perr    = par_q ^ bit_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      cw_q   <= '0;
      syn_q  <= '0;
      ok_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (start_acc) mode_q <= mode_check;
      if (tx_done)
        cw_q <= {rem_next[CC_REM_W-1:1], ~rem_next[0],
                 par_next ^ sent_rem_parity(rem_next)};
      if (rx_done) begin
        syn_q <= {perr, rem_q};
        ok_q  <= (rem_q == '0) && !perr;
      end
      done_q <= tx_done || rx_done;
    end
  end

  assign check_word  = cw_q;
  assign syndrome_lo = syn_q[7:0];
  assign syndrome_hi = syn_q[CW_W-1:8];
  assign word_ok     = ok_q;
  assign word_done   = done_q;

  assert_results_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_done || rx_done) |=> $stable(cw_q) && $stable(syn_q) && $stable(ok_q));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done);
  assert_pass_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_ok |-> syn_q == '0);
  assert_mode_fixed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !word_start |=> mode_q == $past(mode_q));
endmodule

// File: tb/cc_codec_test.sv
module cc_codec_test;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [15:0] GEN = 16'hE815;

  logic clk = 0, rst_n = 0;
  logic bit_valid = 0, bit_in = 0, word_start = 0, mode_check = 0;
  logic [15:0] check_word;
  logic [7:0]  syndrome_lo, syndrome_hi;
  logic        word_ok, word_done;
  int errors = 0, checks = 0;

  cc_codec uut (.clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .word_start(word_start), .mode_check(mode_check), .check_word(check_word),
    .syndrome_lo(syndrome_lo), .syndrome_hi(syndrome_hi), .word_ok(word_ok),
    .word_done(word_done));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Polynomial long division: remainder of val (nbits long) modulo GEN.
  function automatic logic [14:0] poly_mod(logic [127:0] val, int nbits);
    for (int i = nbits - 1; i >= 15; i--)
      if (val[i]) val = val ^ (128'(GEN) << (i - 15));
    return val[14:0];
  endfunction

  function automatic logic [15:0] exp_check(logic [47:0] m);
    logic [14:0] r;
    logic [14:0] sent;
    r = poly_mod(128'(m) << 15, 63);
    sent = {r[14:1], ~r[0]};
    return {sent, ^m ^ ^sent};
  endfunction

  function automatic logic [15:0] exp_syn(logic [63:0] c);
    logic [62:0] d;
    d = {c[63:2], ~c[1]};
    return {^c[63:1] ^ c[0], poly_mod(128'(d) << 15, 78)};
  endfunction

  // Drives n bits of w, first bit = w[n-1]; gap inserts idle cycles with junk data.
  task automatic send(input bit m, input logic [63:0] w, input int n, input bit gap, input bit flip_mode);
    for (int i = 0; i < n; i++) begin
      if (gap && (i % 5 == 2)) begin
        @(negedge clk);
        bit_valid = 0; word_start = 0; bit_in = ~w[n-1-i];
      end
      @(negedge clk);
      bit_valid = 1; word_start = (i == 0); bit_in = w[n-1-i];
      mode_check = (i == 0 || !flip_mode) ? m : ~m;
    end
    @(negedge clk);
    bit_valid = 0; word_start = 0; mode_check = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [47:0] msg;
    logic [15:0] cw, es, syn_prev;
    logic [63:0] word, bad;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(check_word == 0 && syndrome_lo == 0 && syndrome_hi == 0, "R10", {check_word, syndrome_hi, syndrome_lo}, 0);
    chk(!word_ok && !word_done, "R10", {word_ok, word_done}, 0);
    rst_n = 1;

    for (int t = 0; t < 24; t++) begin
      msg = (t == 0) ? 48'h0 : (t == 1) ? {48{1'b1}} : 48'({$urandom(), $urandom()});
      cw = exp_check(msg);
      syn_prev = {syndrome_hi, syndrome_lo};
      send(1'b0, 64'(msg), 48, t[0], 1'b0);
      chk(word_done, "R9", word_done, 1);
      chk(check_word[15:2] == cw[15:2], "R1", check_word, cw);
      chk(check_word[1] == cw[1], "R2", check_word, cw);
      chk(check_word[0] == cw[0], "R3", check_word, cw);
      chk({syndrome_hi, syndrome_lo} == syn_prev, "R9", {syndrome_hi, syndrome_lo}, syn_prev);
      @(negedge clk);
      chk(!word_done, "R9", word_done, 0);
      word = {msg, cw};
      send(1'b1, word, 64, t[1], 1'b0);
      chk(word_ok && {syndrome_hi, syndrome_lo} == 0, "R4", {word_ok, syndrome_hi, syndrome_lo}, 32'h10000);
      chk(check_word == cw, "R9", check_word, cw);
    end

    // R5/R6: every single-bit error position on two messages
    for (int t = 0; t < 2; t++) begin
      msg = t ? 48'hA5C3_0F96_1E2D : 48'h0123_4567_89AB;
      word = {msg, exp_check(msg)};
      for (int p = 0; p < 64; p++) begin
        bad = word ^ (64'd1 << p);
        es = exp_syn(bad);
        send(1'b1, bad, 64, 1'b0, 1'b0);
        chk({syndrome_hi, syndrome_lo} == es, "R5", {syndrome_hi, syndrome_lo}, es);
        chk(syndrome_hi[7] == 1'b1 && !word_ok, "R6", {word_ok, syndrome_hi}, 32'h080);
      end
    end

    // R6: only parity bit wrong
    bad = word ^ 64'd1;
    send(1'b1, bad, 64, 1'b0, 1'b0);
    chk(syndrome_lo == 0 && syndrome_hi == 8'h80 && !word_ok, "R6", {word_ok, syndrome_hi, syndrome_lo}, 32'h8000);

    // R7: aborted word followed by restart
    send(1'b1, 64'hDEAD_BEEF_1234_5678, 30, 1'b0, 1'b0);
    chk(!word_done, "R7", word_done, 0);
    send(1'b1, word, 64, 1'b0, 1'b0);
    chk(word_done && word_ok && {syndrome_hi, syndrome_lo} == 0, "R7", {word_done, word_ok, syndrome_hi, syndrome_lo}, 32'h30000);

    // R8: surplus bits without word_start are ignored
    syn_prev = {syndrome_hi, syndrome_lo};
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k > 0) chk(!word_done, "R8", word_done, 0);
      bit_valid = 1; word_start = 0; bit_in = k[0];
    end
    @(negedge clk); bit_valid = 0;
    @(negedge clk);
    chk(!word_done && word_ok && {syndrome_hi, syndrome_lo} == syn_prev, "R8", {word_done, word_ok, syndrome_hi, syndrome_lo}, {16'h1, syn_prev});

    // R11: mode toggled after the first bit
    bad = word ^ (64'd1 << 40);
    es = exp_syn(bad);
    cw = check_word;
    send(1'b1, bad, 64, 1'b0, 1'b1);
    chk(word_done && {syndrome_hi, syndrome_lo} == es && check_word == cw, "R11", {syndrome_hi, syndrome_lo}, es);
    msg = 48'h5555_AAAA_F00F;
    send(1'b0, 64'(msg), 48, 1'b0, 1'b1);
    chk(word_done && check_word == exp_check(msg), "R11", check_word, exp_check(msg));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule